// File: doc/BRIEF.md
# Signed Sequential Divider

This unit divides a signed two's-complement dividend by a signed divisor. It returns a quotient that is truncated toward zero and a remainder that carries the sign of the dividend. Both operands are reduced to magnitudes when the operation is accepted. A restoring shift-and-subtract loop then produces one quotient bit per clock. A final cycle applies the sign corrections that follow from the original operand signs.

A client asserts `start` for one cycle while the unit is idle, with both operands on the inputs. `busy` stays high while the operation runs. `done` pulses for one cycle when `quotient` and `remainder` become valid, and both outputs then hold until the next operation finishes. A zero divisor does not trap: the loop runs normally and `div_zero` is raised together with `done`.

Top module: `sdiv_unit`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` sampled high while `busy` is low captures both operands, and `busy` is 1 in the next cycle.
- R3: `done` is high for exactly one cycle, WIDTH+1 clock edges after the edge that accepted `start` (16 loop edges and one fix-up edge). `busy` is high from the edge after acceptance until `done` rises, and it is low while `done` is high.
- R4: For a non-zero divisor, `quotient` equals the dividend divided by the divisor, truncated toward zero. A negative quotient is returned when exactly one operand is negative (the XOR of the two sign bits).
- R5: For a non-zero divisor, `remainder` equals dividend − quotient·divisor. Its magnitude is below the divisor's magnitude, and a non-zero remainder has the sign of the dividend.
- R6: The most negative value −32768 is valid for either operand. −32768 / −1 wraps to a quotient of −32768 with remainder 0.
- R7: With a zero divisor, `quotient` is 16'hFFFF (−1) for a dividend ≥ 0 and 16'h0001 for a negative dividend. `remainder` equals the dividend, and `div_zero` is 1 during the `done` cycle only.
- R8: A `start` sampled while `busy` is high is ignored: the running operation's result and timing are unchanged, and no extra `done` is produced.
- R9: `quotient` and `remainder` change only on the edge that raises `done`, and otherwise hold their last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted only while idle |
| dividend | input | 16 | Signed dividend, sampled at acceptance |
| divisor | input | 16 | Signed divisor, sampled at acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| quotient | output | 16 | Signed quotient, truncated toward zero |
| remainder | output | 16 | Signed remainder, sign of the dividend |
| div_zero | output | 1 | Divisor was zero; valid with `done` |

## Verification
Results are due 17 rising edges after the edge that accepts `start`. `busy` is due on the very next edge after acceptance. The driver records the cycle count at each request and pushes the expected quotient, remainder and zero-divisor flag into a queue. The monitor samples on falling edges and pops an item whenever `done` is high, so it checks the values and the exact elapsed cycle count in the same cycle the result appears. Any `done` with an empty queue is reported, which catches a request that should have been ignored while busy. Results are also re-read several cycles after `done` to confirm they hold.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOP = 2'd1,
      ST_FIX  = 2'd2
   } sdiv_state_e;

   localparam int unsigned SDIV_OPERANDS = 2;
   localparam int unsigned SDIV_IDX_DND  = 0;
   localparam int unsigned SDIV_IDX_DVS  = 1;

endpackage

// File: rtl/sdiv_abs.sv
module sdiv_abs #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] val,
   output logic [W-1:0] mag,
   output logic         neg
);
   // magnitude is read as unsigned, so the most negative value maps onto itself correctly
   always_comb begin
      neg = val[W-1];
      mag = neg ? (~val + W'(1)) : val;
   end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] hi,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] dvs,
   output logic [W-1:0] hi_nxt,
   output logic [W-1:0] lo_nxt
);
   logic [W-1:0] hi_sh;
   logic [W:0]   trial;
   logic         borrow;

   always_comb begin
      hi_sh  = {hi[W-2:0], lo[W-1]};
      trial  = {1'b0, hi_sh} - {1'b0, dvs};
      borrow = trial[W];
      hi_nxt = borrow ? hi_sh : trial[W-1:0];
      lo_nxt = {lo[W-2:0], ~borrow};
   end
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] q_mag,
   input  logic [W-1:0] r_mag,
   input  logic         neg_dnd,
   input  logic         neg_dvs,
   output logic [W-1:0] q_out,
   output logic [W-1:0] r_out
);
   logic flip_q;

   always_comb begin
      flip_q = neg_dnd ^ neg_dvs;
      q_out  = flip_q  ? (~q_mag + W'(1)) : q_mag;
      r_out  = neg_dnd ? (~r_mag + W'(1)) : r_mag;
   end
endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
   import sdiv_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic iterate,
   output logic fix,
   output logic busy,
   output logic done
);
   localparam int unsigned CW = $clog2(W + 1);

   sdiv_state_e state;
   logic [CW-1:0] cnt;

   always_comb begin
      load    = (state == ST_IDLE) && start;
      iterate = (state == ST_LOOP);
      fix     = (state == ST_FIX);
      busy    = (state != ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_LOOP;
               cnt   <= CW'(W);
            end
            ST_LOOP: begin
               cnt <= cnt - CW'(1);
               if (cnt == CW'(1)) state <= ST_FIX;
            end
            ST_FIX: begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (state == ST_LOOP && cnt == CW'(W))); // R2

   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOOP) |-> (cnt != '0 && cnt <= CW'(W))); // R3

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOOP && start && cnt != CW'(1)) |=> (state == ST_LOOP && cnt == $past(cnt) - CW'(1))); // R8

endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
   import sdiv_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             div_zero
);
   localparam int unsigned W = WIDTH;

   generate
      if (W < 2) begin : g_bad_width
         $error("sdiv_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic load, iterate, fix;

   logic [SDIV_OPERANDS-1:0][W-1:0] ops;
   logic [SDIV_OPERANDS-1:0][W-1:0] mags;
   logic [SDIV_OPERANDS-1:0]        negs;

   assign ops[SDIV_IDX_DND] = dividend;
   assign ops[SDIV_IDX_DVS] = divisor;

   generate
      for (genvar g = 0; g < SDIV_OPERANDS; g++) begin : g_abs
         sdiv_abs #(.W(W)) u_abs (
            .val (ops[g]),
            .mag (mags[g]),
            .neg (negs[g])
         );
      end
   endgenerate

   logic [W-1:0] hi_q, lo_q, dvs_q;
   logic         neg_dnd_q, neg_dvs_q, dvs_zero_q;
   logic [W-1:0] hi_nxt, lo_nxt;
   logic [W-1:0] q_fix, r_fix;
   logic [W-1:0] q_q, r_q;
   logic         err_q;

   sdiv_ctrl #(.W(W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .load    (load),
      .iterate (iterate),
      .fix     (fix),
      .busy    (busy),
      .done    (done)
   );

   sdiv_step #(.W(W)) u_step (
      .hi     (hi_q),
      .lo     (lo_q),
      .dvs    (dvs_q),
      .hi_nxt (hi_nxt),
      .lo_nxt (lo_nxt)
   );

   sdiv_fixup #(.W(W)) u_fix (
      .q_mag   (lo_q),
      .r_mag   (hi_q),
      .neg_dnd (neg_dnd_q),
      .neg_dvs (neg_dvs_q),
      .q_out   (q_fix),
      .r_out   (r_fix)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q       <= '0;
         lo_q       <= '0;
         dvs_q      <= '0;
         neg_dnd_q  <= 1'b0;
         neg_dvs_q  <= 1'b0;
         dvs_zero_q <= 1'b0;
      end else if (load) begin
         hi_q       <= '0;
         lo_q       <= mags[SDIV_IDX_DND];
         dvs_q      <= mags[SDIV_IDX_DVS];
         neg_dnd_q  <= negs[SDIV_IDX_DND];
         neg_dvs_q  <= negs[SDIV_IDX_DVS];
         dvs_zero_q <= (divisor == '0);
      end else if (iterate) begin
         hi_q <= hi_nxt;
         lo_q <= lo_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q   <= '0;
         r_q   <= '0;
         err_q <= 1'b0;
      end else begin
         err_q <= fix & dvs_zero_q;
         if (fix) begin
            q_q <= q_fix;
            r_q <= r_fix;
         end
      end
   end

   assign quotient  = q_q;
   assign remainder = r_q;
   assign div_zero  = err_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R3

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R3

   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R3

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      div_zero |-> done); // R7

   AST_PARTIAL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      (iterate && !dvs_zero_q) |-> (hi_q < dvs_q)); // R5

   AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && remainder != '0) |-> (remainder[W-1] == neg_dnd_q)); // R5

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(quotient) || !$stable(remainder)) |-> done); // R9

endmodule

// File: tb/tb_sdiv_unit.sv
module tb_sdiv_unit;

   localparam int W = 16;
   localparam int LAT = W + 2;  // cycle-count delta from request negedge to done negedge

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  dividend = '0;
   logic [W-1:0]  divisor = '0;
   logic          busy, done, div_zero;
   logic [W-1:0]  quotient, remainder;

   sdiv_unit #(.WIDTH(W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .dividend  (dividend),
      .divisor   (divisor),
      .busy      (busy),
      .done      (done),
      .quotient  (quotient),
      .remainder (remainder),
      .div_zero  (div_zero)
   );

   always #2 clk = ~clk;

   typedef struct {
      logic [W-1:0] q;
      logic [W-1:0] r;
      logic         e;
      int           at;
      string        qtag;
      string        rtag;
   } item_t;

   item_t sb[$];
   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int issued = 0;
   int completed = 0;
   logic [W-1:0] last_q = '0;
   logic [W-1:0] last_r = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 output logic [W-1:0] q, output logic [W-1:0] r,
                                 output logic e);
      int ai;
      int bi;
      int qi;
      int ri;
      ai = int'($signed(a));
      bi = int'($signed(b));
      if (bi == 0) begin
         q = (ai < 0) ? 16'h0001 : 16'hFFFF;
         r = a;
         e = 1'b1;
      end else begin
         qi = ai / bi;
         ri = ai % bi;
         q = qi[W-1:0];
         r = ri[W-1:0];
         e = 1'b0;
      end
   endfunction

   task automatic issue(logic [W-1:0] a, logic [W-1:0] b, string qtag, string rtag);
      item_t it;
      @(negedge clk);
      while (busy) @(negedge clk);
      model(a, b, it.q, it.r, it.e);
      it.at   = cyc;
      it.qtag = qtag;
      it.rtag = rtag;
      sb.push_back(it);
      issued++;
      start    = 1'b1;
      dividend = a;
      divisor  = b;
      @(negedge clk);
      start = 1'b0;
      chk("R2", "busy after accept", 32'(busy), 32'd1);
   endtask

   // monitor: pops one expected item per done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk("R8", "done with no pending request", 32'd1, 32'd0);
         end else begin
            item_t it;
            it = sb.pop_front();
            completed++;
            chk("R3", "latency", 32'(cyc - it.at), 32'(LAT));
            chk(it.qtag, "quotient", 32'(quotient), 32'(it.q));
            chk(it.rtag, "remainder", 32'(remainder), 32'(it.r));
            chk(it.e ? "R7" : "R4", "div_zero flag", 32'(div_zero), 32'(it.e));
            last_q = it.q;
            last_r = it.r;
         end
      end
   end

   initial begin : watchdog
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      repeat (3) @(negedge clk);
      // R1: outputs idle during reset
      chk("R1", "busy in reset", 32'(busy), 32'd0);
      chk("R1", "done in reset", 32'(done), 32'd0);
      chk("R1", "div_zero in reset", 32'(div_zero), 32'd0);
      chk("R1", "quotient in reset", 32'(quotient), 32'd0);
      chk("R1", "remainder in reset", 32'(remainder), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "busy after reset", 32'(busy), 32'd0);
      chk("R1", "quotient after reset", 32'(quotient), 32'd0);

      // R4 R5: sign combinations
      issue(16'd7, 16'd2, "R4", "R5");
      issue(-16'sd7, 16'd2, "R4", "R5");
      issue(16'd7, -16'sd2, "R4", "R5");
      issue(-16'sd7, -16'sd2, "R4", "R5");
      issue(16'd100, 16'd7, "R4", "R5");
      issue(16'd0, 16'd5, "R4", "R5");
      issue(16'd1, 16'd1, "R4", "R5");
      issue(-16'sd1, -16'sd1, "R4", "R5");
      issue(16'd3, 16'd9, "R4", "R5");

      // R6: most negative operand
      issue(16'h8000, -16'sd1, "R6", "R6");
      issue(16'h8000, 16'd1, "R6", "R6");
      issue(16'd32767, 16'h8000, "R6", "R6");
      issue(16'h8000, 16'h8000, "R6", "R6");
      issue(-16'sd32767, 16'h8000, "R6", "R6");
      issue(16'h8000, 16'd3, "R6", "R6");

      // R7: zero divisor
      issue(16'd5, 16'd0, "R7", "R7");
      issue(-16'sd5, 16'd0, "R7", "R7");
      issue(16'h8000, 16'd0, "R7", "R7");
      issue(16'd0, 16'd0, "R7", "R7");

      // R9: results hold after done
      @(negedge clk);
      while (busy || sb.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
      chk("R9", "quotient held", 32'(quotient), 32'(last_q));
      chk("R9", "remainder held", 32'(remainder), 32'(last_r));

      // R8: start pulses during an operation are ignored
      issue(16'd1234, 16'd10, "R8", "R8");
      repeat (4) @(negedge clk);
      start = 1'b1; dividend = 16'd9; divisor = 16'd4;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      start = 1'b1; dividend = 16'hFFF0; divisor = 16'd0;
      repeat (3) @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      repeat (25) @(negedge clk);
      chk("R8", "completions equal requests", 32'(completed), 32'(issued));
      chk("R9", "quotient held after ignored start", 32'(quotient), 32'(last_q));

      // R4 R5: random operands, some with small divisors
      for (int i = 0; i < 160; i++) begin
         ra = W'($urandom());
         rb = W'($urandom());
         if (i % 4 == 1) rb = W'($signed(rb) >>> 11);
         if (i % 16 == 3) rb = '0;
         issue(ra, rb, (rb == '0) ? "R7" : "R4", (rb == '0) ? "R7" : "R5");
      end

      @(negedge clk);
      while (busy || sb.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R3", "all requests completed", 32'(completed), 32'(issued));
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule